// File: doc/BRIEF.md
# Vector Exponential Seed Unit

This block turns every element of a packed vector into a starting value for a base-2 exponential. For each element it builds a floating-point number with the sign cleared. The exponent field is copied straight out of a fixed slice in the middle of the input element. The fraction comes from a small table of 2^(i/N) − 1 values, and the lowest input bits pick the entry. No arithmetic is performed on the input. The unit raises no exception flags and gives NaN or infinity inputs no special handling: the output follows from the bit mapping alone.

A 2-bit size code selects 16-bit, 32-bit or 64-bit lanes. Every lane of the vector is processed; there is no predication. The byte size code has no meaning for this operation. It is reported through an illegal flag and yields a zero vector. Requests are qualified by a valid strobe, and the result is registered one cycle later. The tables are computed when the design is elaborated, so no table contents appear in the source.

Top module: `vexp_seed_unit`

## Requirements
- R1: The sign bit of every result element (its most significant bit) is 0 for all three lane widths.
- R2: With size code 01 (16-bit lanes), each result lane is {0, in[9:5], T16[in[4:0]]}, where T16[i] = round(1024 × (2^(i/32) − 1)); T16[0] = 0 and T16[16] = 424.
- R3: With size code 10 (32-bit lanes), each result lane is {0, in[13:6], T32[in[5:0]]}, where T32[i] = round(2^23 × (2^(i/64) − 1)).
- R4: With size code 11 (64-bit lanes), each result lane is {0, in[16:6], T64[in[5:0]]}, where T64[i] = round(2^52 × (2^(i/64) − 1)).
- R5: Lane e of a W-bit element size occupies bits [e·W +: W] of both input and output, and all VL/W lanes are produced in the same cycle.
- R6: Size code 00 sets illegal_o together with valid_o, and the result vector is then all zeros.
- R7: valid_o is high exactly in the cycle after a cycle with valid_i high. illegal_o is low for legal codes and whenever valid_o is low. After reset, valid_o, illegal_o and res_o are 0.
- R8: While valid_i is low, res_o keeps its previous value.
- R9: All-ones inputs (NaN patterns) follow the same bit mapping as any other input.
- R10: Two ranges are mapped to exact powers of two. A 16-bit input encoding an integer x with 33 ≤ x < 63 gives the encoding of 2^(x−47). A 32-bit input encoding an integer x with 131073 ≤ x < 131327 gives the encoding of 2^(x−131199).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| size_i | input | 2 | Element size code: 00 illegal, 01 16-bit, 10 32-bit, 11 64-bit |
| src_i | input | VL | Packed source vector |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| illegal_o | output | 1 | Request used the illegal size code |
| res_o | output | VL | Packed result vector |

## Verification
A table lookup result and an illegal-code zeroing can reach the output register in consecutive cycles. A legal result and a hold cycle can also land back to back. The bench provokes both by keeping valid_i high across a legal request, an illegal request and another legal request, and then dropping valid_i. After each edge it judges the flag, the zero vector and every lane against values it computes itself. Full sweeps of every table index in every lane, for all three widths, give the lookup path its own coverage. All-ones patterns and the exact power-of-two ranges are checked as well.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_DOUBLE = 2'b11
    } elem_size_e;

    localparam int GROUP_W = 64;

    localparam int H_EXP_W = 5;
    localparam int H_FRC_W = 10;
    localparam int H_IDX_W = 5;

    localparam int S_EXP_W = 8;
    localparam int S_FRC_W = 23;
    localparam int S_IDX_W = 6;

    localparam int D_EXP_W = 11;
    localparam int D_FRC_W = 52;
    localparam int D_IDX_W = 6;

    // 52-bit fraction of 2^(num/den) in binary64
    function automatic logic [63:0] pow2_frac(input int num, input int den);
        real r;
        logic [63:0] b;
        r = $pow(2.0, real'(num) / real'(den));
        b = $realtobits(r);
        return {12'd0, b[51:0]};
    endfunction

    // round a 52-bit fraction to its top 'keep' bits, nearest
    function automatic logic [63:0] trim_frac(input logic [63:0] f, input int keep);
        logic [63:0] w;
        if (keep >= 52) return f;
        w = f + (64'd1 << (51 - keep));
        return w >> (52 - keep);
    endfunction

endpackage

// File: rtl/vexp_frac_rom.sv
module vexp_frac_rom
    import vexp_pkg::*;
#(
    parameter int FW = 10,
    parameter int IW = 5
) (
    input  logic [IW-1:0] idx_i,
    output logic [FW-1:0] frac_o
);
    localparam int N = 1 << IW;

    logic [FW-1:0] tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        localparam logic [FW-1:0] ENT = FW'(trim_frac(pow2_frac(i, N), FW));
        assign tbl[i] = ENT;
    end

    assign frac_o = tbl[idx_i];

    // R2
    always_comb begin
        if (idx_i == '0) begin
            zero_entry_chk: assert (frac_o == '0);
        end
    end

endmodule

// File: rtl/vexp_group.sv
module vexp_group
    import vexp_pkg::*;
(
    input  logic [GROUP_W-1:0] src_i,
    input  elem_size_e         size_i,
    output logic [GROUP_W-1:0] res_o
);
    localparam int NH = GROUP_W / 16;
    localparam int NS = GROUP_W / 32;

    logic [GROUP_W-1:0] half_res;
    logic [GROUP_W-1:0] single_res;
    logic [GROUP_W-1:0] double_res;

    for (genvar k = 0; k < NH; k++) begin : g_half
        logic [H_FRC_W-1:0] frac;
        vexp_frac_rom #(.FW(H_FRC_W), .IW(H_IDX_W)) u_rom (
            .idx_i  (src_i[16*k +: H_IDX_W]),
            .frac_o (frac)
        );
        assign half_res[16*k +: 16] = {1'b0, src_i[16*k + H_IDX_W +: H_EXP_W], frac};
    end

    for (genvar k = 0; k < NS; k++) begin : g_single
        logic [S_FRC_W-1:0] frac;
        vexp_frac_rom #(.FW(S_FRC_W), .IW(S_IDX_W)) u_rom (
            .idx_i  (src_i[32*k +: S_IDX_W]),
            .frac_o (frac)
        );
        assign single_res[32*k +: 32] = {1'b0, src_i[32*k + S_IDX_W +: S_EXP_W], frac};
    end

    logic [D_FRC_W-1:0] d_frac;
    vexp_frac_rom #(.FW(D_FRC_W), .IW(D_IDX_W)) u_rom_d (
        .idx_i  (src_i[D_IDX_W-1:0]),
        .frac_o (d_frac)
    );
    assign double_res = {1'b0, src_i[D_IDX_W +: D_EXP_W], d_frac};

    logic unused_src;
    assign unused_src = ^src_i;

    always_comb begin
        unique case (size_i)
            SZ_HALF:   res_o = half_res;
            SZ_SINGLE: res_o = single_res;
            SZ_DOUBLE: res_o = double_res;
            default:   res_o = '0;
        endcase
    end

endmodule

// File: rtl/vexp_seed_unit.sv
module vexp_seed_unit
    import vexp_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [1:0]    size_i,
    input  logic [VL-1:0] src_i,
    output logic          valid_o,
    output logic          illegal_o,
    output logic [VL-1:0] res_o
);
    localparam int NG = VL / GROUP_W;

    typedef struct packed {
        logic          valid;
        logic          illegal;
        logic [VL-1:0] res;
    } state_t;

    state_t st_d, st_q;
    elem_size_e size_sel;
    logic [VL-1:0] lane_res;

    assign size_sel = elem_size_e'(size_i);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        vexp_group u_grp (
            .src_i  (src_i[g*GROUP_W +: GROUP_W]),
            .size_i (size_sel),
            .res_o  (lane_res[g*GROUP_W +: GROUP_W])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = valid_i;
        st_d.illegal = 1'b0;
        if (valid_i) begin
            st_d.illegal = (size_sel == SZ_BYTE);
            st_d.res     = (size_sel == SZ_BYTE) ? '0 : lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o   = st_q.valid;
    assign illegal_o = st_q.illegal;
    assign res_o     = st_q.res;

    function automatic logic [VL-1:0] sign_mask(input logic [1:0] s);
        logic [VL-1:0] m;
        int w;
        w = 8 << s;
        for (int b = 0; b < VL; b++) m[b] = (((b + 1) % w) == 0);
        return m;
    endfunction

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R7
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o && !illegal_o);
    // R6
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && size_i == 2'b00) |=> illegal_o);
    // R6
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (valid_o && res_o == '0));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(res_o));
    // R1
    sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && size_i != 2'b00) |=> ((res_o & sign_mask($past(size_i))) == '0));

endmodule

// File: tb/vexp_seed_unit_bench.sv
module vexp_seed_unit_bench;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [1:0]    size_i = 2'b00;
    logic [VL-1:0] src_i = '0;
    logic          valid_o, illegal_o;
    logic [VL-1:0] res_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vexp_seed_unit #(.VL(VL)) u_vexp_seed_unit (
        .clk, .rst_n, .valid_i, .size_i, .src_i, .valid_o, .illegal_o, .res_o
    );

    task automatic chk(input bit ok, input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input int sz, input logic [63:0] e);
        logic [63:0] r;
        real p;
        int idx;
        r = '0;
        case (sz)
            1: begin
                idx = int'(e[4:0]);
                p = $pow(2.0, real'(idx) / 32.0);
                r[15:0] = {1'b0, e[9:5], 10'(int'(1024.0 * (p - 1.0)))};
            end
            2: begin
                idx = int'(e[5:0]);
                p = $pow(2.0, real'(idx) / 64.0);
                r[31:0] = {1'b0, e[13:6], 23'(int'(8388608.0 * (p - 1.0)))};
            end
            3: begin
                idx = int'(e[5:0]);
                p = $pow(2.0, real'(idx) / 64.0);
                r = {1'b0, e[16:6], 52'(longint'(4503599627370496.0 * (p - 1.0)))};
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [VL-1:0] model_vec(input int sz, input logic [VL-1:0] v);
        logic [VL-1:0] out;
        int w;
        logic [63:0] m;
        out = '0;
        w = 8 << sz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int k = 0; k < VL / w; k++) begin
            out = out | (VL'(model(sz, 64'(v >> (k * w)) & m)) << (k * w));
        end
        return out;
    endfunction

    task automatic send(input logic [1:0] sz, input logic [VL-1:0] v);
        valid_i = 1'b1;
        size_i  = sz;
        src_i   = v;
        @(negedge clk);
    endtask

    task automatic idle();
        valid_i = 1'b0;
        @(negedge clk);
    endtask

    // R1 R2 R3 R4 R5: per-lane comparison after one request
    task automatic lane_check(input int sz, input logic [VL-1:0] v, input string req);
        logic [VL-1:0] exp;
        int w;
        logic [63:0] m;
        exp = model_vec(sz, v);
        w = 8 << sz;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int k = 0; k < VL / w; k++) begin
            chk(((64'(res_o >> (k * w)) & m) == (64'(exp >> (k * w)) & m)) && valid_o && !illegal_o,
                req, VL'(64'(res_o >> (k * w)) & m), VL'(64'(exp >> (k * w)) & m));
        end
    endtask

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [VL-1:0] v, prev, exp;
        string tag;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(valid_o == 0 && illegal_o == 0 && res_o == '0, "R7 reset", res_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R1: full index sweep, rotated per lane, random upper bits
        for (int sz = 1; sz <= 3; sz++) begin
            int w, n, ib;
            w  = 8 << sz;
            ib = (sz == 1) ? 5 : 6;
            n  = 1 << ib;
            tag = (sz == 1) ? "R2 R5 R1 half sweep" : (sz == 2) ? "R3 R5 R1 single sweep" : "R4 R5 R1 double sweep";
            for (int t = 0; t < n; t++) begin
                v = rand_vec();
                for (int k = 0; k < VL / w; k++) begin
                    for (int b = 0; b < ib; b++) v[k*w + b] = ((t + k * 5) % n) >> b & 1;
                end
                send(2'(sz), v);
                lane_check(sz, v, tag);
            end
        end

        // R2 specific entries: index 0 and index 16
        v = '0;
        v[4:0] = 5'd16;
        v[9:5] = 5'd15;
        send(2'b01, v);
        chk(res_o[15:0] == {1'b0, 5'd15, 10'd424}, "R2 entry16", VL'(res_o[15:0]), VL'({1'b0, 5'd15, 10'd424}));
        chk(res_o[31:16] == 16'h0, "R2 entry0", VL'(res_o[31:16]), '0);

        // R9 all-ones (NaN) inputs
        for (int sz = 1; sz <= 3; sz++) begin
            send(2'(sz), '1);
            lane_check(sz, '1, "R9 nan pattern");
        end

        // R10 half: x in [33,63) -> 2^(x-47)
        for (int x = 33; x < 63; x++) begin
            v = '0;
            for (int k = 0; k < VL / 16; k++) v[k*16 +: 16] = {1'b0, 5'd20, 10'((x - 32) << 5)};
            send(2'b01, v);
            chk(res_o[15:0] == {1'b0, 5'(x - 47 + 15), 10'd0}, "R10 half power",
                VL'(res_o[15:0]), VL'({1'b0, 5'(x - 47 + 15), 10'd0}));
        end
        // R10 single: x in [131073,131327) -> 2^(x-131199)
        for (int x = 131073; x < 131327; x += 23) begin
            v = '0;
            for (int k = 0; k < VL / 32; k++) v[k*32 +: 32] = {1'b0, 8'd144, 23'((x - 131072) << 6)};
            send(2'b10, v);
            chk(res_o[31:0] == {1'b0, 8'(x - 131199 + 127), 23'd0}, "R10 single power",
                VL'(res_o[31:0]), VL'({1'b0, 8'(x - 131199 + 127), 23'd0}));
        end

        // R6 R7: legal, illegal, legal back to back, then hold (R8)
        v = rand_vec();
        send(2'b10, v);
        lane_check(2, v, "R7 b2b legal first");
        send(2'b00, rand_vec());
        chk(valid_o && illegal_o && res_o == '0, "R6 illegal zero", res_o, '0);
        v = rand_vec();
        send(2'b11, v);
        chk(!illegal_o, "R7 illegal clears", VL'(illegal_o), '0);
        lane_check(3, v, "R7 b2b legal after illegal");
        prev = res_o;
        size_i = 2'b01;
        src_i = rand_vec();
        idle();
        chk(!valid_o && !illegal_o, "R7 valid drops", VL'({valid_o, illegal_o}), '0);
        chk(res_o == prev, "R8 hold", res_o, prev);
        size_i = 2'b00;
        idle();
        chk(res_o == prev && !illegal_o, "R8 hold illegal code", res_o, prev);

        // R6 illegal after hold, then recovery
        send(2'b00, '1);
        chk(illegal_o && valid_o && res_o == '0, "R6 illegal all ones", res_o, '0);
        v = rand_vec();
        send(2'b01, v);
        exp = model_vec(1, v);
        chk(res_o == exp && !illegal_o, "R5 full vector half", res_o, exp);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule